// File: doc/BRIEF.md
# BCD Alarm Compare Unit

This block holds a programmable alarm time as four byte-wide BCD registers: seconds, minutes, hours and day of month. Once per second an external timekeeper raises a tick and presents the current time in BCD. The block compares that time with the stored alarm and, on a match, raises a one-clock interrupt pulse, provided the interrupt enable input is high.

The top bit of each alarm register is a mask bit. A masked field drops out of the comparison. The pattern of mask bits selects how often the alarm repeats: monthly, daily, hourly, every minute or every second. The write port checks each value before storing it. A value outside the legal range for its field is discarded without any indication, and the register keeps its old contents. A read port returns the stored bytes at any time. The time count itself, any interrupt policy beyond the single enable, and retention of state without power all belong to other blocks.

Top module: `bcd_alarm_cmp`

## Requirements
- R1: While reset is asserted and just after it is released, all four alarm registers read 0x00 and `alarm_irq` is low.
- R2: Register address 0 holds alarm seconds, 1 holds minutes, 2 holds hours and 3 holds date. An accepted write stores all eight bits, including bit 7, and `rd_data` returns the stored byte for `rd_addr` in the same cycle.
- R3: A write to address 0 or 1 is dropped when the decoded value of bits 6:4 (tens) and 3:0 (units) exceeds 59.
- R4: A write to address 2 is dropped when the decoded value of bits 5:4 (tens) and 3:0 (units) exceeds 23.
- R5: A write to address 3 is dropped when bits 4:0 are all zero.
- R6: When a field is compared, the comparison uses the stored seconds bits 6:0, minutes bits 6:0, hours bits 5:0 and date bits 4:0, which must equal `now_sec`, `now_min`, `now_hour` and `now_date` exactly. The other stored bits do not take part.
- R7: With no mask bit set, the alarm fires only when date, hours, minutes and seconds all match.
- R8: With only the date mask set, the alarm fires when hours, minutes and seconds match.
- R9: With only the date and hours masks set, the alarm fires when minutes and seconds match.
- R10: With only the date, hours and minutes masks set, the alarm fires when seconds match.
- R11: With any other mask pattern, including all four set, the alarm fires on every tick.
- R12: `alarm_irq` is high for exactly the one clock after a clock edge at which `tick`, `irq_en` and a match were all present. At all other times it is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for one register |
| wr_addr | input | 2 | Register address for the write |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Register address for readback |
| rd_data | output | 8 | Stored byte at `rd_addr` |
| tick | input | 1 | One-clock pulse once per second |
| irq_en | input | 1 | Enables the interrupt pulse |
| now_sec | input | 7 | Current seconds, BCD |
| now_min | input | 7 | Current minutes, BCD |
| now_hour | input | 6 | Current hours, BCD |
| now_date | input | 5 | Current date, BCD |
| alarm_irq | output | 1 | Alarm interrupt pulse |

## Verification
The properties assume that `tick` is a single-clock pulse that is never high on two consecutive edges. They also assume that the current-time inputs are steady at each tick edge. The bench raises `tick` for exactly one clock, separates ticks by idle clocks, and changes the time inputs only on falling edges. Every byte value is swept through each of the four write addresses. All sixteen mask patterns are crossed with a full match and with a single-field mismatch in each field.

// File: rtl/bcd_alarm_pkg.sv
package bcd_alarm_pkg;

  localparam int unsigned FIELD_CNT = 4;
  localparam int unsigned ADDR_W    = $clog2(FIELD_CNT);
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned MASK_BIT  = BYTE_W - 1;
  localparam int unsigned SEC_W     = 7;
  localparam int unsigned MIN_W     = 7;
  localparam int unsigned HOUR_W    = 6;
  localparam int unsigned DATE_W    = 5;
  localparam int unsigned SEC_MAX   = 59;
  localparam int unsigned MIN_MAX   = 59;
  localparam int unsigned HOUR_MAX  = 23;

  typedef enum logic [ADDR_W-1:0] {
    FLD_SEC  = 2'd0,
    FLD_MIN  = 2'd1,
    FLD_HOUR = 2'd2,
    FLD_DATE = 2'd3
  } fld_e;

  typedef enum logic [2:0] {
    RATE_MONTH,
    RATE_DAY,
    RATE_HOUR,
    RATE_MIN,
    RATE_SEC
  } rate_e;

  typedef logic [FIELD_CNT-1:0][BYTE_W-1:0] bank_t;

  // tens * 10 + units, wide enough for 15*10+15
  function automatic logic [7:0] bcd_decode(input logic [3:0] tens, input logic [3:0] units);
    return ({4'b0, tens} * 8'd10) + {4'b0, units};
  endfunction

  // Range check applied before a byte is stored (bit 7 is the mask, never checked)
  function automatic logic field_ok(input fld_e fld, input logic [6:0] d);
    case (fld)
      FLD_SEC:  return bcd_decode({1'b0, d[6:4]}, d[3:0]) <= 8'(SEC_MAX);
      FLD_MIN:  return bcd_decode({1'b0, d[6:4]}, d[3:0]) <= 8'(MIN_MAX);
      FLD_HOUR: return bcd_decode({2'b0, d[5:4]}, d[3:0]) <= 8'(HOUR_MAX);
      FLD_DATE: return |d[4:0];
      default:  return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/bcd_alarm_regs.sv
module bcd_alarm_regs
  import bcd_alarm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [BYTE_W-1:0] rd_data,
  output bank_t             bank_o
);

  bank_t                bank_q;
  bank_t                bank_d;
  logic [FIELD_CNT-1:0] accept;
  logic                 bank_ce;

  // per-field address decode and range qualification
  for (genvar g = 0; g < FIELD_CNT; g++) begin : g_fld
    localparam fld_e FLD = fld_e'(ADDR_W'(g));
    logic sel;
    assign sel       = wr_en && (wr_addr == ADDR_W'(g));
    assign accept[g] = sel && field_ok(FLD, wr_data[6:0]);
  end

  assign bank_ce = |accept;

  always_comb begin
    bank_d = bank_q;
    for (int i = 0; i < FIELD_CNT; i++) begin
      if (accept[i]) begin
        bank_d[i] = wr_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= '0;
    end else if (bank_ce) begin
      bank_q <= bank_d;
    end
  end

  assign rd_data = bank_q[rd_addr];
  assign bank_o  = bank_q;

endmodule

// File: rtl/bcd_alarm_match.sv
module bcd_alarm_match
  import bcd_alarm_pkg::*;
(
  input  logic [SEC_W-1:0]     alm_sec,
  input  logic [MIN_W-1:0]     alm_min,
  input  logic [HOUR_W-1:0]    alm_hour,
  input  logic [DATE_W-1:0]    alm_date,
  input  logic [FIELD_CNT-1:0] mask,
  input  logic [SEC_W-1:0]     now_sec,
  input  logic [MIN_W-1:0]     now_min,
  input  logic [HOUR_W-1:0]    now_hour,
  input  logic [DATE_W-1:0]    now_date,
  output logic                 hit
);

  logic [FIELD_CNT-1:0] eq;
  logic [FIELD_CNT-1:0] need;
  rate_e                rate;

  assign eq[FLD_SEC]  = (alm_sec  == now_sec);
  assign eq[FLD_MIN]  = (alm_min  == now_min);
  assign eq[FLD_HOUR] = (alm_hour == now_hour);
  assign eq[FLD_DATE] = (alm_date == now_date);

  // mask order {date, hour, min, sec}; only four patterns narrow the rate
  always_comb begin
    case (mask)
      4'b0000: rate = RATE_MONTH;
      4'b1000: rate = RATE_DAY;
      4'b1100: rate = RATE_HOUR;
      4'b1110: rate = RATE_MIN;
      default: rate = RATE_SEC;
    endcase
  end

  always_comb begin
    case (rate)
      RATE_MONTH: need = 4'b1111;
      RATE_DAY:   need = 4'b0111;
      RATE_HOUR:  need = 4'b0011;
      RATE_MIN:   need = 4'b0001;
      default:    need = 4'b0000;
    endcase
  end

  assign hit = &(eq | ~need);

endmodule

// File: rtl/bcd_alarm_cmp.sv
module bcd_alarm_cmp
  import bcd_alarm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [BYTE_W-1:0] rd_data,
  input  logic              tick,
  input  logic              irq_en,
  input  logic [SEC_W-1:0]  now_sec,
  input  logic [MIN_W-1:0]  now_min,
  input  logic [HOUR_W-1:0] now_hour,
  input  logic [DATE_W-1:0] now_date,
  output logic              alarm_irq
);

  bank_t                bank;
  logic [FIELD_CNT-1:0] mask;
  logic                 hit;
  logic                 irq_d;
  logic                 irq_q;

  bcd_alarm_regs i_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .bank_o  (bank)
  );

  for (genvar g = 0; g < FIELD_CNT; g++) begin : g_mask
    assign mask[g] = bank[g][MASK_BIT];
  end

  bcd_alarm_match i_match (
    .alm_sec  (bank[FLD_SEC][SEC_W-1:0]),
    .alm_min  (bank[FLD_MIN][MIN_W-1:0]),
    .alm_hour (bank[FLD_HOUR][HOUR_W-1:0]),
    .alm_date (bank[FLD_DATE][DATE_W-1:0]),
    .mask     (mask),
    .now_sec  (now_sec),
    .now_min  (now_min),
    .now_hour (now_hour),
    .now_date (now_date),
    .hit      (hit)
  );

  assign irq_d = tick && irq_en && hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
    end
  end

  assign alarm_irq = irq_q;

endmodule

// File: rtl/bcd_alarm_cmp_chk.sv
module bcd_alarm_cmp_chk
  import bcd_alarm_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [BYTE_W-1:0] wr_data,
  input logic              tick,
  input logic              irq_en,
  input logic              alarm_irq,
  input bank_t             bank
);

  logic       sec_rng;
  logic       hr_rng;
  logic       date_rng;
  logic       wr_legal;
  logic [3:0] msk;
  logic       free_run;

  // range rules phrased per tens digit
  assign sec_rng  = (wr_data[6:4] <= 3'd4) || ((wr_data[6:4] == 3'd5) && (wr_data[3:0] <= 4'd9));
  assign hr_rng   = (wr_data[5:4] == 2'd0) ||
                    ((wr_data[5:4] == 2'd1) && (wr_data[3:0] <= 4'd13)) ||
                    ((wr_data[5:4] == 2'd2) && (wr_data[3:0] <= 4'd3));
  assign date_rng = (wr_data[4:0] != 5'd0);

  always_comb begin
    case (wr_addr)
      2'd0, 2'd1: wr_legal = sec_rng;
      2'd2:       wr_legal = hr_rng;
      default:    wr_legal = date_rng;
    endcase
  end

  assign msk      = {bank[3][7], bank[2][7], bank[1][7], bank[0][7]};
  assign free_run = (msk != 4'b0000) && (msk != 4'b1000) && (msk != 4'b1100) && (msk != 4'b1110);

  // R12
  irq_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_irq |-> $past(tick && irq_en));

  // R3
  sec_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr == 2'd0) && !sec_rng) |=> $stable(bank[0]));

  // R3
  min_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr == 2'd1) && !sec_rng) |=> $stable(bank[1]));

  // R4
  hour_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr == 2'd2) && !hr_rng) |=> $stable(bank[2]));

  // R5
  date_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr == 2'd3) && !date_rng) |=> $stable(bank[3]));

  // R2
  accept_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_legal) |=> (bank[$past(wr_addr)] == $past(wr_data)));

  // R11
  every_second_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && irq_en && free_run) |=> alarm_irq);

endmodule

bind bcd_alarm_cmp bcd_alarm_cmp_chk i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .tick      (tick),
  .irq_en    (irq_en),
  .alarm_irq (alarm_irq),
  .bank      (bank)
);

// File: tb/test_bcd_alarm_cmp.sv
module test_bcd_alarm_cmp;

  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 100000;

  logic       clk;
  logic       rst_n;
  logic       wr_en;
  logic [1:0] wr_addr;
  logic [7:0] wr_data;
  logic [1:0] rd_addr;
  logic [7:0] rd_data;
  logic       tick;
  logic       irq_en;
  logic [6:0] now_sec;
  logic [6:0] now_min;
  logic [5:0] now_hour;
  logic [4:0] now_date;
  logic       alarm_irq;

  logic [7:0] exp_bank [4];
  int         checks;
  int         errors;
  bit         done;

  bcd_alarm_cmp i_bcd_alarm_cmp (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .tick      (tick),
    .irq_en    (irq_en),
    .now_sec   (now_sec),
    .now_min   (now_min),
    .now_hour  (now_hour),
    .now_date  (now_date),
    .alarm_irq (alarm_irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic bit legal(input int a, input logic [7:0] d);
    int v;
    case (a)
      0, 1: begin v = int'(d[6:4]) * 10 + int'(d[3:0]); return v <= 59; end
      2:    begin v = int'(d[5:4]) * 10 + int'(d[3:0]); return v <= 23; end
      default: return d[4:0] != 5'd0;
    endcase
  endfunction

  task automatic write_reg(input int a, input logic [7:0] d);
    string tag;
    bit    ok;
    ok = legal(a, d);
    tag = ok ? "R2" : (a < 2 ? "R3" : (a == 2 ? "R4" : "R5"));
    @(negedge clk);
    wr_en   = 1'b1;
    wr_addr = 2'(a);
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (ok) exp_bank[a] = d;
    rd_addr = 2'(a);
    #1;
    check(tag, rd_data, exp_bank[a]);
  endtask

  task automatic tick_once(input bit exp_fire, input string tag);
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    check(tag, {7'd0, alarm_irq}, {7'd0, exp_fire});
    @(negedge clk);
    check("R12", {7'd0, alarm_irq}, 8'd0);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    checks   = 0;
    errors   = 0;
    done     = 1'b0;
    rst_n    = 1'b0;
    wr_en    = 1'b0;
    wr_addr  = '0;
    wr_data  = '0;
    rd_addr  = '0;
    tick     = 1'b0;
    irq_en   = 1'b1;
    now_sec  = '0;
    now_min  = '0;
    now_hour = '0;
    now_date = '0;
    for (int i = 0; i < 4; i++) exp_bank[i] = 8'h00;

    // R1: reset state
    repeat (3) @(negedge clk);
    for (int a = 0; a < 4; a++) begin
      rd_addr = 2'(a);
      #1;
      check("R1", rd_data, 8'h00);
    end
    check("R1", {7'd0, alarm_irq}, 8'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {7'd0, alarm_irq}, 8'd0);

    // R2..R5: every byte through every address
    for (int a = 0; a < 4; a++) begin
      for (int d = 0; d < 256; d++) begin
        write_reg(a, 8'(d));
      end
    end

    // R7..R11: all mask patterns, full match and single-field misses
    for (int m = 0; m < 16; m++) begin
      bit    need_s, need_m, need_h, need_d;
      string tag;
      write_reg(0, 8'h30 | (m[0] ? 8'h80 : 8'h00));
      write_reg(1, 8'h15 | (m[1] ? 8'h80 : 8'h00));
      write_reg(2, 8'h12 | (m[2] ? 8'h80 : 8'h00));
      write_reg(3, 8'h07 | (m[3] ? 8'h80 : 8'h00));
      need_d = (m == 0);
      need_h = (m == 0) || (m == 8);
      need_m = (m == 0) || (m == 8) || (m == 12);
      need_s = (m == 0) || (m == 8) || (m == 12) || (m == 14);
      tag = (m == 0) ? "R7" : (m == 8) ? "R8" : (m == 12) ? "R9" : (m == 14) ? "R10" : "R11";
      for (int p = 0; p < 5; p++) begin
        bit miss;
        now_sec  = (p == 1) ? 7'h31 : 7'h30;
        now_min  = (p == 2) ? 7'h16 : 7'h15;
        now_hour = (p == 3) ? 6'h13 : 6'h12;
        now_date = (p == 4) ? 5'h08 : 5'h07;
        miss = (need_s && p == 1) || (need_m && p == 2) ||
               (need_h && p == 3) || (need_d && p == 4);
        tick_once(!miss, tag);
      end
    end

    // R6: stored bits outside the value field do not take part
    write_reg(0, 8'h30);
    write_reg(1, 8'h15);
    write_reg(2, 8'h52);
    write_reg(3, 8'h67);
    now_sec = 7'h30; now_min = 7'h15; now_hour = 6'h12; now_date = 5'h07;
    tick_once(1'b1, "R6");
    now_date = 5'h17;
    tick_once(1'b0, "R6");

    // R12: enable low suppresses, idle clocks stay low
    write_reg(0, 8'h80);
    irq_en = 1'b0;
    tick_once(1'b0, "R12");
    irq_en = 1'b1;
    repeat (4) begin
      @(negedge clk);
      check("R12", {7'd0, alarm_irq}, 8'd0);
    end
    tick_once(1'b1, "R11");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule